// File: doc/BRIEF.md
# Bit-Serial CRC-16 Transmitter With Gapless Checksum Append

This block protects a serial bit stream with a 16-bit cyclic check value. Message bits arrive one per clock, each with a valid strobe. Each accepted bit is passed to the serial output one cycle later. The same bit also updates a check register on the fly. The register uses the direct (non-augmented) form: the incoming bit is combined with the bit leaving the top of the register, and that combined bit drives the feedback taps. After the last message bit has been accepted, the register therefore already holds the final check value. No zero bits have to be pushed through it.

An end-of-message strobe starts the append phase. The 16 check bits then leave on the same serial output, most significant first. When the strobe comes with the final message bit, the first check bit directly follows that bit, with no idle cycle between them. During the append phase, new message bits and strobes are ignored. A single-cycle done pulse marks the last check bit. The register is then reloaded with its initial value for the next message.

Top module: `crc16_ser_tx`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) drives `ser_vld_o` and `done_o` low. It also returns the check register to its initial value and the sequencer to the message phase.
- R2: A message bit is accepted when `msg_vld_i` is high outside the append phase. It appears on `ser_bit_o`, with `ser_vld_o` high, in the next cycle.
- R3: The check value uses generator x^16 + x^12 + x^5 + 1 (low taps 0x1021) and initial value 0x0000. The message bits are fed in the order given, and no trailing zeros are added. The nine ASCII bytes "123456789", sent MSB first, yield 0x31C3.
- R4: The 16 check bits appear on consecutive cycles, most significant first, with `ser_vld_o` high. When `msg_eom_i` is high in the same cycle as the last message bit, the first check bit appears in the cycle right after that bit.
- R5: `done_o` is high for exactly one cycle: the cycle in which the sixteenth check bit is on `ser_bit_o`.
- R6: During the append phase, `msg_vld_i`, `msg_bit_i` and `msg_eom_i` have no effect. The following message's check value starts again from the initial value.
- R7: If `msg_eom_i` arrives in a cycle without a message bit, the check value of the bits accepted so far is appended. For an empty message this gives 16 zero bits.
- R8: `ser_vld_o` is low in every cycle that carries neither a passed-through message bit nor a check bit. `done_o` is never high while `ser_vld_o` is low.
- R9: A reset during the append phase aborts it: no further check bits and no done pulse follow. The next message is encoded from the initial value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msg_vld_i | input | 1 | Message bit present this cycle |
| msg_bit_i | input | 1 | Message bit value |
| msg_eom_i | input | 1 | End of message; starts the checksum append |
| ser_bit_o | output | 1 | Serial output: message bits, then check bits |
| ser_vld_o | output | 1 | `ser_bit_o` carries a bit this cycle |
| done_o | output | 1 | High with the last check bit |

## Verification
The bench builds the block with its default parameters: a 16-bit register, taps 0x1021 and an all-zero initial value. These are the settings for which a well-known check value exists. The settings allow the standard nine-byte check string to be compared against 0x31C3 at the serial output. Independent expected values come from an augmented long-division model. With the default 16-cycle append window, the tests stay short. That leaves room to drive junk bits and end-of-message strobes through the whole window. It also covers an empty message, an end strobe arriving after an idle cycle, and a reset that lands in the middle of the checksum.

// File: rtl/crc16_ser_tx_pkg.sv
package crc16_ser_tx_pkg;

  // Sequencer phase: message pass-through or checksum append
  typedef enum logic {
    PH_MSG = 1'b0,
    PH_APP = 1'b1
  } tx_phase_e;

endpackage

// File: rtl/crc16_ser_core.sv
module crc16_ser_core #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h1021,
  parameter logic [W-1:0]    INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_init,
  input  logic         step_en,
  input  logic         step_bit,
  input  logic         shift_en,
  output logic [W-1:0] crc_q,
  output logic         top_bit
);

  // Direct-form step: message bit meets the departing top bit,
  // and their sum decides whether the taps are applied.
  function automatic logic [W-1:0] crc_feed(input logic [W-1:0] c, input logic b);
    logic fb;
    fb = c[W-1] ^ b;
    crc_feed = {c[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  // Plain shift used while the check bits are being emitted
  function automatic logic [W-1:0] crc_drain(input logic [W-1:0] c);
    crc_drain = {c[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)            crc_q <= INIT;
    else if (load_init) crc_q <= INIT;
    else if (step_en)   crc_q <= crc_feed(crc_q, step_bit);
    else if (shift_en)  crc_q <= crc_drain(crc_q);
  end

  assign top_bit = crc_q[W-1];

endmodule

// File: rtl/crc16_ser_seq.sv
module crc16_ser_seq
  import crc16_ser_tx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic msg_vld,
  input  logic msg_eom,
  output logic accept,
  output logic app_active,
  output logic last_chk
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  tx_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign accept     = (phase_q == PH_MSG) && msg_vld;
  assign start      = (phase_q == PH_MSG) && msg_eom;
  assign app_active = (phase_q == PH_APP);
  assign last_chk   = app_active && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_MSG;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_MSG: begin
          cnt_q <= '0;
          if (start) phase_q <= PH_APP;
        end
        PH_APP: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_chk) phase_q <= PH_MSG;
        end
        default: phase_q <= PH_MSG;
      endcase
    end
  end

endmodule

// File: rtl/crc16_ser_out.sv
module crc16_ser_out (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic msg_bit,
  input  logic app_active,
  input  logic chk_bit,
  input  logic last_chk,
  output logic ser_bit,
  output logic ser_vld,
  output logic done
);

  logic nxt_bit;

  always_comb begin
    if (app_active)  nxt_bit = chk_bit;
    else if (accept) nxt_bit = msg_bit;
    else             nxt_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_bit <= 1'b0;
      ser_vld <= 1'b0;
      done    <= 1'b0;
    end else begin
      ser_bit <= nxt_bit;
      ser_vld <= accept | app_active;
      done    <= last_chk;
    end
  end

endmodule

// File: rtl/crc16_ser_tx.sv
module crc16_ser_tx #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic msg_vld_i,
  input  logic msg_bit_i,
  input  logic msg_eom_i,
  output logic ser_bit_o,
  output logic ser_vld_o,
  output logic done_o
);

  // Internal events, named for the checker
  logic         accept;
  logic         app_active;
  logic         last_chk;
  logic         chk_bit;
  logic [W-1:0] crc_q;

  crc16_ser_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .msg_vld    (msg_vld_i),
    .msg_eom    (msg_eom_i),
    .accept     (accept),
    .app_active (app_active),
    .last_chk   (last_chk)
  );

  crc16_ser_core #(.W(W), .POLY(POLY), .INIT(INIT)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load_init (last_chk),
    .step_en   (accept),
    .step_bit  (msg_bit_i),
    .shift_en  (app_active),
    .crc_q     (crc_q),
    .top_bit   (chk_bit)
  );

  crc16_ser_out u_out (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .msg_bit    (msg_bit_i),
    .app_active (app_active),
    .chk_bit    (chk_bit),
    .last_chk   (last_chk),
    .ser_bit    (ser_bit_o),
    .ser_vld    (ser_vld_o),
    .done       (done_o)
  );

endmodule

// File: rtl/crc16_ser_tx_chk.sv
module crc16_ser_tx_chk #(
  parameter int           W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         msg_vld_i,
  input logic         msg_bit_i,
  input logic         ser_bit_o,
  input logic         ser_vld_o,
  input logic         done_o,
  input logic         app_active,
  input logic         last_chk,
  input logic [W-1:0] crc_q
);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_vld_i && !app_active) |=> (ser_vld_o && ser_bit_o == $past(msg_bit_i)));

  // R4
  chk_bit_vld_chk: assert property (@(posedge clk) disable iff (rst)
    app_active |=> ser_vld_o);

  // R4
  chk_bit_msb_chk: assert property (@(posedge clk) disable iff (rst)
    app_active |=> (ser_bit_o == $past(crc_q[W-1])));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ser_vld_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!app_active && !msg_vld_i) |=> !ser_vld_o);

  // R6
  append_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (app_active && !last_chk) |=> (crc_q == {$past(crc_q[W-2:0]), 1'b0}));

  // R6
  append_reload_chk: assert property (@(posedge clk) disable iff (rst)
    last_chk |=> (crc_q == INIT && !app_active && done_o));

endmodule

bind crc16_ser_tx crc16_ser_tx_chk #(.W(W), .INIT(INIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msg_vld_i  (msg_vld_i),
  .msg_bit_i  (msg_bit_i),
  .ser_bit_o  (ser_bit_o),
  .ser_vld_o  (ser_vld_o),
  .done_o     (done_o),
  .app_active (app_active),
  .last_chk   (last_chk),
  .crc_q      (crc_q)
);

// File: tb/tb_crc16_ser_tx.sv
`timescale 1ns/1ps
module tb_crc16_ser_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_vld_i = 1'b0;
  logic msg_bit_i = 1'b0;
  logic msg_eom_i = 1'b0;
  logic ser_bit_o, ser_vld_o, done_o;

  always #10 clk = ~clk;

  crc16_ser_tx dut (
    .clk(clk), .rst(rst), .msg_vld_i(msg_vld_i), .msg_bit_i(msg_bit_i),
    .msg_eom_i(msg_eom_i), .ser_bit_o(ser_bit_o), .ser_vld_o(ser_vld_o),
    .done_o(done_o)
  );

  typedef struct packed {
    logic       b;
    logic       last;
    logic       contig;
    logic [3:0] req;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  msg_q[$];
  int          checks = 0;
  int          errors = 0;
  logic        mon_en = 1'b0;
  logic        prev_vld = 1'b0;
  logic [15:0] cap = '0;
  logic [15:0] last_crc = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Augmented long-division model: shift bits in at the bottom,
  // then flush sixteen zeros.
  function automatic logic [15:0] ref_crc(input logic [7:0] d[$]);
    logic [15:0] c;
    logic        t;
    c = 16'h0000;
    foreach (d[i]) begin
      for (int k = 7; k >= 0; k--) begin
        t = c[15];
        c = {c[14:0], d[i][k]};
        if (t) c = c ^ 16'h1021;
      end
    end
    for (int k = 0; k < 16; k++) begin
      t = c[15];
      c = {c[14:0], 1'b0};
      if (t) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // Monitor: compares the serial stream against the scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (ser_vld_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R8", "unexpected serial bit", 32'(ser_bit_o), 32'hx);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(ser_bit_o == e.b, $sformatf("R%0d", e.req), "serial bit value",
                32'(ser_bit_o), 32'(e.b));
          check(done_o == e.last, "R5", "done alignment", 32'(done_o), 32'(e.last));
          if (e.contig)
            check(prev_vld, "R4", "gap before check bit", 32'(prev_vld), 32'h1);
          if (e.last) last_crc = {cap[14:0], ser_bit_o};
        end
        cap = {cap[14:0], ser_bit_o};
      end else begin
        check(!done_o, "R8", "done without valid", 32'(done_o), 32'h0);
      end
      prev_vld = ser_vld_o;
    end
  end

  // Driver: sends msg_q MSB first, pushes expected items.
  // eom_sep: end strobe in its own cycle after one idle cycle.
  // gap: idle cycles between message bits. junk: noise during append.
  task automatic send_msg(input int gap, input bit eom_sep, input bit junk);
    logic [15:0] c;
    int          nbits;
    int          n;
    bit          first_contig;
    c     = ref_crc(msg_q);
    nbits = msg_q.size() * 8;
    n     = 0;
    foreach (msg_q[i]) begin
      for (int k = 7; k >= 0; k--) begin
        @(negedge clk);
        msg_vld_i = 1'b1;
        msg_bit_i = msg_q[i][k];
        n++;
        msg_eom_i = (!eom_sep && n == nbits);
        exp_q.push_back('{b: msg_q[i][k], last: 1'b0, contig: 1'b0, req: 4'd2});
        if (gap > 0 && n != nbits) begin
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            msg_vld_i = 1'b0;
            msg_eom_i = 1'b0;
          end
        end
      end
    end
    if (eom_sep || nbits == 0) begin
      if (nbits != 0) begin
        @(negedge clk);
        msg_vld_i = 1'b0;
        msg_eom_i = 1'b0;
      end
      @(negedge clk);
      msg_vld_i = 1'b0;
      msg_eom_i = 1'b1;
    end
    first_contig = !(eom_sep || nbits == 0);
    for (int i = 15; i >= 0; i--) begin
      exp_q.push_back('{b: c[i], last: (i == 0), contig: (i == 15) ? first_contig : 1'b1,
                        req: (nbits == 0 || eom_sep) ? 4'd7 : 4'd3});
    end
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      msg_vld_i = junk;
      msg_bit_i = junk & j[0];
      msg_eom_i = junk & ~j[1];
    end
    @(negedge clk);
    msg_vld_i = 1'b0;
    msg_bit_i = 1'b0;
    msg_eom_i = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 64 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, "scoreboard drained", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic load_check_string();
    msg_q.delete();
    for (int i = 0; i < 9; i++) msg_q.push_back(8'h31 + 8'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!ser_vld_o, "R1", "valid in reset", 32'(ser_vld_o), 32'h0);
    check(!done_o, "R1", "done in reset", 32'(done_o), 32'h0);
    rst = 1'b0;
    mon_en = 1'b1;
    @(negedge clk);
    check(!ser_vld_o, "R8", "idle after reset", 32'(ser_vld_o), 32'h0);

    // R3: check string, gapless append
    load_check_string();
    send_msg(0, 1'b0, 1'b0);
    wait_drain("R3");
    check(last_crc == 16'h31C3, "R3", "check string value", 32'(last_crc), 32'h31C3);

    // R6: junk during append, then same message again from initial value
    send_msg(0, 1'b0, 1'b1);
    wait_drain("R6");
    check(last_crc == 16'h31C3, "R6", "value after junk append", 32'(last_crc), 32'h31C3);

    // R2, R8: bits separated by idle cycles
    msg_q.delete();
    msg_q.push_back(8'hA5);
    msg_q.push_back(8'h0F);
    msg_q.push_back(8'hFF);
    send_msg(2, 1'b0, 1'b1);
    wait_drain("R2");

    // R7: end strobe after an idle cycle
    msg_q.delete();
    msg_q.push_back(8'h80);
    msg_q.push_back(8'h01);
    send_msg(0, 1'b1, 1'b0);
    wait_drain("R7");

    // R7: empty message gives sixteen zeros
    msg_q.delete();
    send_msg(0, 1'b0, 1'b1);
    wait_drain("R7");
    check(last_crc == 16'h0000, "R7", "empty message check", 32'(last_crc), 32'h0);

    // R9: reset in the middle of the append phase
    mon_en = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk);
      msg_vld_i = 1'b1;
      msg_bit_i = k[0];
      msg_eom_i = (k == 0);
    end
    @(negedge clk);
    msg_vld_i = 1'b0;
    msg_eom_i = 1'b0;
    repeat (4) @(negedge clk);
    check(ser_vld_o, "R9", "append running before reset", 32'(ser_vld_o), 32'h1);
    rst = 1'b1;
    @(negedge clk);
    check(!ser_vld_o, "R9", "valid after mid-append reset", 32'(ser_vld_o), 32'h0);
    check(!done_o, "R9", "done after mid-append reset", 32'(done_o), 32'h0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!ser_vld_o && !done_o, "R9", "no tail after abort",
            {30'h0, ser_vld_o, done_o}, 32'h0);
    end
    exp_q.delete();
    prev_vld = 1'b0;
    mon_en = 1'b1;
    load_check_string();
    send_msg(1, 1'b0, 1'b0);
    wait_drain("R9");
    check(last_crc == 16'h31C3, "R9", "value after abort", 32'(last_crc), 32'h31C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule